// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds a bank of eight ownership flags that two agents, a left side and a right side, use to coordinate exclusive use of a shared resource. Each side has its own access pins: a semaphore enable, a memory enable (which must be low for a semaphore access), a write strobe, a 3-bit flag index, write data and read data. A side asks for a flag by writing a 0 in bit 0 and gives it up by writing a 1. Reading a flag returns whether the reader holds it, with that bit copied onto every data bit.

Each flag remembers a pending request from the side that is not holding it. When the holder releases, a pending request from the other side is granted in that same update, so the waiting side does not have to write again. Accesses are single-cycle register operations with no back-pressure. There is no valid/ready handshake: a write takes effect at the clock edge where it is presented, and read data is combinational from the current state.

Top module: `sem_bank`

## Requirements
- R1: After reset every flag is free with no pending request, so a read of any flag from either side returns 8'hFF.
- R2: An access happens only when the side's semaphore enable is high and its memory enable is low. Any other combination leaves every flag unchanged, and that side's read data is 8'h00.
- R3: The 3-bit index selects one of eight flags. A write changes only the indexed flag.
- R4: Writes use only bit 0 of the write data. A read (strobe low) returns 8'h00 when the reader holds the flag and 8'hFF otherwise.
- R5: Writing 0 to a free flag gives the token to the writer from the next cycle on. The writer then reads 8'h00 and the other side reads 8'hFF.
- R6: Writing 0 to a flag that the other side holds leaves ownership unchanged, and the reads of both sides stay the same.
- R7: When the holder writes 1 while the other side has a pending request, the other side holds the token from the next cycle.
- R8: When the holder writes 1 and there is no pending request, the flag becomes free and both sides read 8'hFF.
- R9: A side that writes 1 while it is only waiting withdraws its pending request. A later release by the holder then frees the flag.
- R10: If both sides write 0 to a free flag in the same cycle, the left side gets the token and the right request stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| l_sem_en | input | 1 | Left semaphore enable |
| l_mem_en | input | 1 | Left memory enable, must be low for an access |
| l_wr | input | 1 | Left write strobe (1 write, 0 read) |
| l_addr | input | 3 | Left flag index |
| l_wdata | input | 8 | Left write data, only bit 0 used |
| l_rdata | output | 8 | Left read data |
| r_sem_en | input | 1 | Right semaphore enable |
| r_mem_en | input | 1 | Right memory enable, must be low for an access |
| r_wr | input | 1 | Right write strobe |
| r_addr | input | 3 | Right flag index |
| r_wdata | input | 8 | Right write data, only bit 0 used |
| r_rdata | output | 8 | Right read data |

## Verification
A corrupted owner field shows up as soon as either side reads that flag: the read returns 8'h00 on the wrong side, or on both sides. A lost or stray pending request stays hidden until the holder releases the flag. The release then either frees the flag or hands it over, so the error appears one cycle after that release write. The scenarios therefore read both sides immediately after every release.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic [1:0] {
    OWN_FREE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_t;
endpackage

// File: rtl/sem_port_dec.sv
module sem_port_dec #(
  parameter int NUM_FLAGS = 8,
  parameter int DATA_W    = 8,
  localparam int ADDR_W   = $clog2(NUM_FLAGS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sem_en,
  input  logic                 mem_en,
  input  logic                 wr,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [NUM_FLAGS-1:0] held,
  output logic [NUM_FLAGS-1:0] wr_vec,
  output logic                 wr_bit,
  output logic [DATA_W-1:0]    rdata
);
  logic acc;

  assign acc    = sem_en && !mem_en;
  assign wr_bit = wdata[0];

  always_comb begin
    wr_vec = '0;
    if (acc && wr) wr_vec[addr] = 1'b1;
  end

  always_comb begin
    rdata = '0;
    if (acc && !wr) rdata = {DATA_W{~held[addr]}};
  end

  // R3: at most one flag strobed per side per cycle
  a_r3_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_vec));
  // R2: no access means no strobe reaches any flag
  a_r2_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!sem_en || mem_en) |-> (wr_vec == '0));
endmodule

// File: rtl/sem_flag.sv
module sem_flag
  import sem_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_l,
  input  logic wd_l,
  input  logic wr_r,
  input  logic wd_r,
  output logic held_l,
  output logic held_r
);
  owner_t owner_q, owner_n, owner_mid;
  logic   req_l_q, req_r_q, req_l_n, req_r_n;
  logic   want_l, want_r, rel;

  always_comb begin
    rel    = (wr_l && wd_l && owner_q == OWN_LEFT) ||
             (wr_r && wd_r && owner_q == OWN_RIGHT);
    want_l = (req_l_q || (wr_l && !wd_l)) && !(wr_l && wd_l);
    want_r = (req_r_q || (wr_r && !wd_r)) && !(wr_r && wd_r);
    owner_mid = rel ? OWN_FREE : owner_q;
    owner_n   = owner_mid;
    if (owner_mid == OWN_FREE) begin
      if (want_l)      owner_n = OWN_LEFT;
      else if (want_r) owner_n = OWN_RIGHT;
    end
    req_l_n = want_l && (owner_n != OWN_LEFT);
    req_r_n = want_r && (owner_n != OWN_RIGHT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q <= OWN_FREE;
      req_l_q <= 1'b0;
      req_r_q <= 1'b0;
    end else begin
      owner_q <= owner_n;
      req_l_q <= req_l_n;
      req_r_q <= req_r_n;
    end
  end

  assign held_l = (owner_q == OWN_LEFT);
  assign held_r = (owner_q == OWN_RIGHT);

  // R9: the holder never also carries a pending request
  a_r9_no_self_req: assert property (@(posedge clk) disable iff (!rst_n)
    !(held_l && req_l_q) && !(held_r && req_r_q));
  // R6: a right claim against a left holder leaves ownership alone
  a_r6_keep_owner: assert property (@(posedge clk) disable iff (!rst_n)
    (held_l && wr_r && !wd_r && !(wr_l && wd_l)) |=> held_l);
  // R7: release with a waiting right side hands over
  a_r7_handoff: assert property (@(posedge clk) disable iff (!rst_n)
    (held_l && wr_l && wd_l && req_r_q) |=> held_r);
  // R8: release with nobody waiting frees the flag
  a_r8_to_free: assert property (@(posedge clk) disable iff (!rst_n)
    (held_l && wr_l && wd_l && !req_r_q && !(wr_r && !wd_r)) |=> (!held_l && !held_r));
  // R10: simultaneous claims on a free flag favour the left side
  a_r10_left_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!held_l && !held_r && wr_l && !wd_l && wr_r && !wd_r) |=> (held_l && req_r_q));
endmodule

// File: rtl/sem_bank.sv
module sem_bank #(
  parameter int NUM_FLAGS = 8,
  parameter int DATA_W    = 8,
  localparam int ADDR_W   = $clog2(NUM_FLAGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_sem_en,
  input  logic              l_mem_en,
  input  logic              l_wr,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              r_sem_en,
  input  logic              r_mem_en,
  input  logic              r_wr,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata
);
  logic [NUM_FLAGS-1:0] wv_l, wv_r, held_l, held_r;
  logic                 wb_l, wb_r;

  sem_port_dec #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_dec_l (
    .clk(clk), .rst_n(rst_n), .sem_en(l_sem_en), .mem_en(l_mem_en),
    .wr(l_wr), .addr(l_addr), .wdata(l_wdata), .held(held_l),
    .wr_vec(wv_l), .wr_bit(wb_l), .rdata(l_rdata));

  sem_port_dec #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_dec_r (
    .clk(clk), .rst_n(rst_n), .sem_en(r_sem_en), .mem_en(r_mem_en),
    .wr(r_wr), .addr(r_addr), .wdata(r_wdata), .held(held_r),
    .wr_vec(wv_r), .wr_bit(wb_r), .rdata(r_rdata));

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    sem_flag u_flag (
      .clk(clk), .rst_n(rst_n),
      .wr_l(wv_l[g]), .wd_l(wb_l), .wr_r(wv_r[g]), .wd_r(wb_r),
      .held_l(held_l[g]), .held_r(held_r[g]));
  end

  // R5: a token is never held by both sides at once
  a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (held_l & held_r) == '0);
  // R4: read data is all zeros or all ones
  a_r4_replicated: assert property (@(posedge clk) disable iff (!rst_n)
    (l_rdata == '0 || l_rdata == '1) && (r_rdata == '0 || r_rdata == '1));
endmodule

// File: tb/sem_bank_tb_top.sv
module sem_bank_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       l_sem_en = 0, l_mem_en = 0, l_wr = 0;
  logic [2:0] l_addr = 0;
  logic [7:0] l_wdata = 0;
  logic [7:0] l_rdata;
  logic       r_sem_en = 0, r_mem_en = 0, r_wr = 0;
  logic [2:0] r_addr = 0;
  logic [7:0] r_wdata = 0;
  logic [7:0] r_rdata;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sem_bank dut_i (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    l_sem_en = 0; l_mem_en = 0; l_wr = 0;
    r_sem_en = 0; r_mem_en = 0; r_wr = 0;
  endtask

  // side 0 = left, 1 = right; one write cycle
  task automatic wr(input bit side, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    if (!side) begin l_sem_en = 1; l_mem_en = 0; l_wr = 1; l_addr = a; l_wdata = d; end
    else       begin r_sem_en = 1; r_mem_en = 0; r_wr = 1; r_addr = a; r_wdata = d; end
    @(negedge clk);
    idle();
  endtask

  task automatic wr_both(input logic [2:0] a, input logic [7:0] dl, input logic [7:0] dr);
    @(negedge clk);
    l_sem_en = 1; l_wr = 1; l_addr = a; l_wdata = dl;
    r_sem_en = 1; r_wr = 1; r_addr = a; r_wdata = dr;
    @(negedge clk);
    idle();
  endtask

  task automatic rd(input string req, input logic [2:0] a, input logic [7:0] el, input logic [7:0] er);
    l_sem_en = 1; l_mem_en = 0; l_wr = 0; l_addr = a;
    r_sem_en = 1; r_mem_en = 0; r_wr = 0; r_addr = a;
    #1;
    chk({req, " left"}, l_rdata, el);
    chk({req, " right"}, r_rdata, er);
    idle();
  endtask

  task automatic t_reset();
    for (int i = 0; i < 8; i++) rd("R1 reset", 3'(i), 8'hFF, 8'hFF);
  endtask

  task automatic t_gate();
    @(negedge clk);
    l_sem_en = 1; l_mem_en = 1; l_wr = 1; l_addr = 3'd1; l_wdata = 8'h00;
    r_sem_en = 0; r_wr = 1; r_addr = 3'd1; r_wdata = 8'h00;
    @(negedge clk);
    l_wr = 0;
    #1 chk("R2 mem_en blocks read", l_rdata, 8'h00);
    idle();
    rd("R2 no write taken", 3'd1, 8'hFF, 8'hFF);
  endtask

  task automatic t_claim_select();
    wr(0, 3'd2, 8'hFE);              // bit0 = 0 -> claim, R4
    rd("R5 R4 claim", 3'd2, 8'h00, 8'hFF);
    rd("R3 other flag", 3'd3, 8'hFF, 8'hFF);
    wr(0, 3'd2, 8'h01);
    rd("R8 freed", 3'd2, 8'hFF, 8'hFF);
  endtask

  task automatic t_handoff();
    wr(0, 3'd4, 8'h00);
    wr(1, 3'd4, 8'h00);
    rd("R6 no change", 3'd4, 8'h00, 8'hFF);
    wr(1, 3'd4, 8'h00);               // repeat claim still ignored
    rd("R6 repeat", 3'd4, 8'h00, 8'hFF);
    wr(0, 3'd4, 8'h01);
    rd("R7 handoff", 3'd4, 8'hFF, 8'h00);
    wr(1, 3'd4, 8'h01);
    rd("R8 right release", 3'd4, 8'hFF, 8'hFF);
  endtask

  task automatic t_withdraw();
    wr(1, 3'd5, 8'h00);
    wr(0, 3'd5, 8'h00);
    wr(0, 3'd5, 8'h01);               // left withdraws its wait
    rd("R9 still right", 3'd5, 8'hFF, 8'h00);
    wr(1, 3'd5, 8'h01);
    rd("R9 freed not handed", 3'd5, 8'hFF, 8'hFF);
  endtask

  task automatic t_tie();
    wr_both(3'd7, 8'h00, 8'h00);
    rd("R10 left wins", 3'd7, 8'h00, 8'hFF);
    wr(0, 3'd7, 8'h01);
    rd("R10 right pending granted", 3'd7, 8'hFF, 8'h00);
    wr(1, 3'd7, 8'h01);
    rd("R10 free", 3'd7, 8'hFF, 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_gate();
    t_claim_select();
    t_handoff();
    t_withdraw();
    t_tie();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=hang expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule